// File: doc/BRIEF.md
# Module Power and Sleep Controller

This block gates the clock and sets the reset state of a set of peripheral modules. The modules are grouped into a few power domains, and module `m` belongs to domain `m % NUM_DOM`. Software writes the state it wants for each module into that module's control word. Nothing moves until software writes a go bit for the domain. The block then walks the domain through its transition. A busy flag shows the transition is running. When it finishes, the module status words change together.

If a domain is powered off and software asks for it to come on, the transition first raises an external power request. It then waits until software sets a power-good flag in the domain control word. Only after that do the modules move. A module that leaves the enabled state normally waits for an idle acknowledge from the module. A per-module force flag skips that wait.

The register file is 32 bits wide with a 4-byte stride. Reads are combinational from `rd_addr`. Writes are single-cycle strobes.

Top module: `modpwr_ctrl`

## Requirements
- R1: After reset every domain status word (0x200 + 4·d) reads 1 and every domain control word (0x300 + 4·d) reads 0x1. Every module status word (0x800 + 4·m) reads 0. Every module control word (0xA00 + 4·m) reads 0x100. The busy word (0x128) and the power request word (0x070) read 0. `mod_clk_en` is all zeros and `mod_lrst_n` is all ones.
- R2: The module control word holds these fields, and they read back as written:
  - the requested state in bits 1:0;
  - the active-low local reset in bit 8;
  - the force flag in bit 31.
  The module status word shows the current state in bits 5:0, using 0 = reset with clock gated, 1 = synchronous reset, 2 = disabled, 3 = enabled.
- R3: Writing 1 to bit d of the go word (0x120) starts a transition of domain d. Bit d of the busy word then reads 1. When no wait applies, it reads 1 for exactly `SETTLE_CYC` cycles after the accepting write and then clears.
- R4: A go to a domain whose status reads 0 while its control bit 0 is 1 sets bit d of `pwr_req` and of word 0x070. The domain stays busy in that state.
- R5: A pending power-up proceeds once bit 8 (power good) of the domain control word is 1. At that point `pwr_req` clears, the modules move, and the domain status reads 1 at completion.
- R6: Bit 12 of a module status word and `mod_clk_en[m]` are 1 exactly when the module's current state is 3.
- R7: `mod_lrst_n[m]` follows bit 8 of the module control word at once and does not depend on the module's state or on transitions.
- R8: A module's current state changes only when a transition of its own domain completes. At that point it takes the requested state.
- R9: A go to a powered domain whose control bit 0 is 0 leaves the domain status reading 0 once the transition completes.
- R10: A module leaving state 3 without its force flag holds the transition until `mod_idle_ack[m]` is 1. With the force flag set, the transition completes after `SETTLE_CYC` cycles whatever the acknowledge.
- R11: A go bit for a domain that is already busy is ignored and does not lengthen the running transition.
- R12: The following read as 0:
  - unmapped offsets;
  - misaligned offsets;
  - indices beyond `NUM_DOM` or `NUM_MOD`.
  Writes to the status, busy and request words have no effect.
- R13: One go write with several bits set starts independent transitions in each of those domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| mod_idle_ack | input | NUM_MOD | Per-module idle acknowledge |
| pwr_req | output | NUM_DOM | Per-domain external power request |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_lrst_n | output | NUM_MOD | Per-module local reset, active low |

## Verification
The assertions assume three things about the inputs:
- software leaves a domain's module control words alone while that domain is busy, because the requested state is sampled live at completion;
- an idle acknowledge, once raised, is held until the commit;
- the power-good flag is written only after the request is seen.

The stimulus writes module targets only while their domain is idle. It raises acknowledges between transitions or during a stalled one and keeps them steady. It sets power good after checking that the request is visible. The behavioural model in the bench compares every output and the read port on each cycle.

// File: rtl/modpwr_pkg.sv
package modpwr_pkg;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_PREQ  = 12'h070;
   localparam logic [ADDR_W-1:0] A_GO    = 12'h120;
   localparam logic [ADDR_W-1:0] A_BUSY  = 12'h128;
   localparam logic [ADDR_W-1:0] A_DSTAT = 12'h200;
   localparam logic [ADDR_W-1:0] A_DCTL  = 12'h300;
   localparam logic [ADDR_W-1:0] A_MSTAT = 12'h800;
   localparam logic [ADDR_W-1:0] A_MCTL  = 12'hA00;

   localparam int unsigned B_NEXTON = 0;
   localparam int unsigned B_PGOOD  = 8;
   localparam int unsigned B_LRST   = 8;
   localparam int unsigned B_CLKACT = 12;
   localparam int unsigned B_FORCE  = 31;

   typedef enum logic [1:0] {
      MST_RST_GATED = 2'd0,
      MST_SYNC_RST  = 2'd1,
      MST_OFF       = 2'd2,
      MST_ON        = 2'd3
   } mst_e;

   typedef enum logic [1:0] {
      DPH_IDLE = 2'd0,
      DPH_PWR  = 2'd1,
      DPH_MOVE = 2'd2
   } dph_e;

endpackage

// File: rtl/modpwr_mod_slot.sv
module modpwr_mod_slot
   import modpwr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [1:0]        tgt_wd,
   input  logic              lrst_wd,
   input  logic              force_wd,
   input  logic              commit,
   input  logic              idle_ack,
   output logic [DATA_W-1:0] ctl_rd,
   output logic [DATA_W-1:0] stat_rd,
   output logic              ready,
   output logic              clk_en,
   output logic              lrst_n
);

   mst_e cur_q, tgt_q;
   logic force_q, lrst_q;
   logic leaving_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= MST_RST_GATED;
         tgt_q   <= MST_RST_GATED;
         force_q <= 1'b0;
         lrst_q  <= 1'b1;
      end else begin
         if (ctl_we) begin
            tgt_q   <= mst_e'(tgt_wd);
            force_q <= force_wd;
            lrst_q  <= lrst_wd;
         end
         if (commit) begin
            cur_q <= tgt_q;
         end
      end
   end

   assign leaving_on = (cur_q == MST_ON) && (tgt_q != MST_ON);
   assign ready      = !leaving_on || force_q || idle_ack;
   assign clk_en     = (cur_q == MST_ON);
   assign lrst_n     = lrst_q;

   always_comb begin
      ctl_rd          = '0;
      ctl_rd[1:0]     = tgt_q;
      ctl_rd[B_LRST]  = lrst_q;
      ctl_rd[B_FORCE] = force_q;
      stat_rd           = '0;
      stat_rd[1:0]      = cur_q;
      stat_rd[B_CLKACT] = (cur_q == MST_ON);
   end

   AST_STATE_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q != $past(cur_q)) |-> $past(commit)) else $error("state moved without commit"); // R8
   AST_LRST_UNTOUCHED_BY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(commit) && !$past(ctl_we)) |-> (lrst_n == $past(lrst_n))) else $error("local reset moved on commit"); // R7
   AST_CLK_RISES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(commit)) else $error("clock enable rose without commit"); // R6
   AST_LEAVE_ON_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && leaving_on && !force_q) |-> idle_ack) else $error("left enabled without idle ack"); // R10

endmodule

// File: rtl/modpwr_dom_seq.sv
module modpwr_dom_seq
   import modpwr_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              next_on_wd,
   input  logic              pgood_wd,
   input  logic              go,
   input  logic              all_ready,
   output logic              busy,
   output logic              pwr_req,
   output logic              commit,
   output logic              dom_on,
   output logic [DATA_W-1:0] ctl_rd
);

   localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   dph_e             ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             on_q, preq_q, next_q, pg_q;

   assign commit = (ph_q == DPH_MOVE) && (cnt_q == LAST) && all_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= DPH_IDLE;
         cnt_q  <= '0;
         on_q   <= 1'b1;
         preq_q <= 1'b0;
         next_q <= 1'b1;
         pg_q   <= 1'b0;
      end else begin
         if (ctl_we) begin
            next_q <= next_on_wd;
            pg_q   <= pgood_wd;
         end
         case (ph_q)
            DPH_IDLE: begin
               if (go) begin
                  if (!on_q && next_q) begin
                     ph_q   <= DPH_PWR;
                     preq_q <= 1'b1;
                  end else begin
                     ph_q  <= DPH_MOVE;
                     cnt_q <= '0;
                  end
               end
            end
            DPH_PWR: begin
               if (pg_q) begin
                  ph_q   <= DPH_MOVE;
                  cnt_q  <= '0;
                  preq_q <= 1'b0;
               end
            end
            DPH_MOVE: begin
               if (cnt_q != LAST) begin
                  cnt_q <= cnt_q + 1'b1;
               end else if (all_ready) begin
                  ph_q <= DPH_IDLE;
                  on_q <= next_q;
               end
            end
            default: ph_q <= DPH_IDLE;
         endcase
      end
   end

   assign busy    = (ph_q != DPH_IDLE);
   assign pwr_req = preq_q;
   assign dom_on  = on_q;

   always_comb begin
      ctl_rd           = '0;
      ctl_rd[B_NEXTON] = next_q;
      ctl_rd[B_PGOOD]  = pg_q;
   end

   AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go)) else $error("busy without go"); // R3
   AST_BUSY_DROPS_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy) else $error("busy after commit"); // R3
   AST_REQ_ONLY_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_req |-> (!dom_on && busy)) else $error("request on a live domain"); // R4
   AST_REQ_HELD_UNTIL_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_req && !pg_q) |=> pwr_req) else $error("request dropped early"); // R5
   AST_ON_CHANGES_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_on != $past(dom_on)) |-> $past(commit)) else $error("domain status moved without commit"); // R9

endmodule

// File: rtl/modpwr_ctrl.sv
module modpwr_ctrl
   import modpwr_pkg::*;
#(
   parameter int unsigned NUM_DOM    = 2,
   parameter int unsigned NUM_MOD    = 6,
   parameter int unsigned SETTLE_CYC = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_MOD-1:0] mod_idle_ack,
   output logic [NUM_DOM-1:0] pwr_req,
   output logic [NUM_MOD-1:0] mod_clk_en,
   output logic [NUM_MOD-1:0] mod_lrst_n
);

   if (NUM_DOM < 1 || NUM_DOM > 32) begin : g_bad_dom
      $error("NUM_DOM must lie in 1..32");
   end
   if (NUM_MOD < 1 || NUM_MOD > 128) begin : g_bad_mod
      $error("NUM_MOD must lie in 1..128");
   end

   logic               go_hit;
   logic               unused_wdata;
   logic [NUM_DOM-1:0] dom_go, dom_busy, dom_on, dom_commit;
   logic [NUM_MOD-1:0] mod_ready;
   logic [DATA_W-1:0]  dctl_rd  [NUM_DOM];
   logic [DATA_W-1:0]  mctl_rd  [NUM_MOD];
   logic [DATA_W-1:0]  mstat_rd [NUM_MOD];

   assign go_hit       = wr_en && (wr_addr == A_GO);
   assign unused_wdata = ^wr_data;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      localparam logic [ADDR_W-1:0] CTL_A = A_DCTL + ADDR_W'(4 * d);
      logic all_rdy;

      assign dom_go[d] = go_hit && wr_data[d];

      always_comb begin
         all_rdy = 1'b1;
         for (int m = 0; m < NUM_MOD; m++) begin
            if ((m % NUM_DOM) == d) all_rdy = all_rdy && mod_ready[m];
         end
      end

      modpwr_dom_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctl_we     (wr_en && (wr_addr == CTL_A)),
         .next_on_wd (wr_data[B_NEXTON]),
         .pgood_wd   (wr_data[B_PGOOD]),
         .go         (dom_go[d]),
         .all_ready  (all_rdy),
         .busy       (dom_busy[d]),
         .pwr_req    (pwr_req[d]),
         .commit     (dom_commit[d]),
         .dom_on     (dom_on[d]),
         .ctl_rd     (dctl_rd[d])
      );
   end

   for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      localparam int unsigned      DOM_IDX = m % NUM_DOM;
      localparam logic [ADDR_W-1:0] CTL_A  = A_MCTL + ADDR_W'(4 * m);

      modpwr_mod_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_we   (wr_en && (wr_addr == CTL_A)),
         .tgt_wd   (wr_data[1:0]),
         .lrst_wd  (wr_data[B_LRST]),
         .force_wd (wr_data[B_FORCE]),
         .commit   (dom_commit[DOM_IDX]),
         .idle_ack (mod_idle_ack[m]),
         .ctl_rd   (mctl_rd[m]),
         .stat_rd  (mstat_rd[m]),
         .ready    (mod_ready[m]),
         .clk_en   (mod_clk_en[m]),
         .lrst_n   (mod_lrst_n[m])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_PREQ) rd_data[NUM_DOM-1:0] = pwr_req;
      if (rd_addr == A_BUSY) rd_data[NUM_DOM-1:0] = dom_busy;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (rd_addr == A_DSTAT + ADDR_W'(4 * d)) rd_data = {{(DATA_W-1){1'b0}}, dom_on[d]};
         if (rd_addr == A_DCTL + ADDR_W'(4 * d))  rd_data = dctl_rd[d];
      end
      for (int m = 0; m < NUM_MOD; m++) begin
         if (rd_addr == A_MSTAT + ADDR_W'(4 * m)) rd_data = mstat_rd[m];
         if (rd_addr == A_MCTL + ADDR_W'(4 * m))  rd_data = mctl_rd[m];
      end
   end

endmodule

// File: tb/modpwr_ctrl_bench.sv
module modpwr_ctrl_bench;
   localparam int ND = 2;
   localparam int NM = 6;
   localparam int ST = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [11:0]   rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NM-1:0] mod_idle_ack = '0;
   logic [ND-1:0] pwr_req;
   logic [NM-1:0] mod_clk_en;
   logic [NM-1:0] mod_lrst_n;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   modpwr_ctrl #(.NUM_DOM(ND), .NUM_MOD(NM), .SETTLE_CYC(ST)) u_modpwr_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .mod_idle_ack(mod_idle_ack),
      .pwr_req(pwr_req), .mod_clk_en(mod_clk_en), .mod_lrst_n(mod_lrst_n));

   // behavioural reference
   int ph [ND];
   int cnt [ND];
   bit on [ND], preq [ND], dnext [ND], dpg [ND];
   int cur [NM], tgt [NM];
   bit frc [NM], lrs [NM];

   always @(posedge clk) begin
      bit rdy [NM];
      bit all;
      if (!rst_n) begin
         for (int d = 0; d < ND; d++) begin
            ph[d] = 0; cnt[d] = 0; on[d] = 1; preq[d] = 0; dnext[d] = 1; dpg[d] = 0;
         end
         for (int m = 0; m < NM; m++) begin
            cur[m] = 0; tgt[m] = 0; frc[m] = 0; lrs[m] = 1;
         end
      end else begin
         for (int m = 0; m < NM; m++)
            rdy[m] = !(cur[m] == 3 && tgt[m] != 3) || frc[m] || mod_idle_ack[m];
         for (int d = 0; d < ND; d++) begin
            if (ph[d] == 0) begin
               if (wr_en && wr_addr == 12'h120 && wr_data[d]) begin
                  if (!on[d] && dnext[d]) begin ph[d] = 1; preq[d] = 1; end
                  else begin ph[d] = 2; cnt[d] = 0; end
               end
            end else if (ph[d] == 1) begin
               if (dpg[d]) begin ph[d] = 2; cnt[d] = 0; preq[d] = 0; end
            end else begin
               if (cnt[d] < ST - 1) cnt[d]++;
               else begin
                  all = 1;
                  for (int m = 0; m < NM; m++) if (m % ND == d) all = all && rdy[m];
                  if (all) begin
                     for (int m = 0; m < NM; m++) if (m % ND == d) cur[m] = tgt[m];
                     on[d] = dnext[d];
                     ph[d] = 0;
                  end
               end
            end
         end
         if (wr_en) begin
            for (int m = 0; m < NM; m++)
               if (wr_addr == 12'hA00 + 4 * m) begin
                  tgt[m] = wr_data[1:0]; lrs[m] = wr_data[8]; frc[m] = wr_data[31];
               end
            for (int d = 0; d < ND; d++)
               if (wr_addr == 12'h300 + 4 * d) begin
                  dnext[d] = wr_data[0]; dpg[d] = wr_data[8];
               end
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      logic [31:0] r;
      r = '0;
      for (int d = 0; d < ND; d++) begin
         if (a == 12'h070) r[d] = preq[d];
         if (a == 12'h128) r[d] = (ph[d] != 0);
         if (a == 12'h200 + 4 * d) r = {31'd0, on[d]};
         if (a == 12'h300 + 4 * d) r = {23'd0, dpg[d], 7'd0, dnext[d]};
      end
      for (int m = 0; m < NM; m++) begin
         if (a == 12'h800 + 4 * m) r = {19'd0, (cur[m] == 3), 10'd0, 2'(cur[m])};
         if (a == 12'hA00 + 4 * m) r = {frc[m], 22'd0, lrs[m], 6'd0, 2'(tgt[m])};
      end
      return r;
   endfunction

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         cmp(rd_data, exp_rd(rd_addr), "R2 read port");
         for (int m = 0; m < NM; m++) begin
            cmp({31'd0, mod_clk_en[m]}, {31'd0, (cur[m] == 3)}, "R6 clk_en");
            cmp({31'd0, mod_lrst_n[m]}, {31'd0, lrs[m]}, "R7 lrst_n");
         end
         for (int d = 0; d < ND; d++)
            cmp({31'd0, pwr_req[d]}, {31'd0, preq[d]}, "R4 pwr_req");
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] v);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(posedge clk); #1;
      rd_addr = a;
      @(negedge clk);
      cmp(rd_data, exp, req);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle(4); #1 rst_n = 1'b1;
      // R1 reset values
      chk_rd(12'h200, 32'h1, "R1 dstat0");
      chk_rd(12'h204, 32'h1, "R1 dstat1");
      chk_rd(12'h304, 32'h1, "R1 dctl1");
      chk_rd(12'h800, 32'h0, "R1 mstat0");
      chk_rd(12'hA14, 32'h100, "R1 mctl5");
      chk_rd(12'h128, 32'h0, "R1 busy");
      chk_rd(12'h070, 32'h0, "R1 preq");
      cmp({26'd0, mod_clk_en}, 32'h0, "R1 clk_en");
      cmp({26'd0, mod_lrst_n}, 32'h3F, "R1 lrst_n");

      // R3 R6 R8 R11: enable modules 0 and 2, repeat go while busy
      wr(12'hA00, 32'h103);
      wr(12'hA08, 32'h103);
      wr(12'hA0C, 32'h103);
      wr(12'h120, 32'h1);
      wr(12'h120, 32'h1);
      chk_rd(12'h128, 32'h0, "R11 busy not extended");
      chk_rd(12'h800, 32'h1003, "R6 mstat0 enabled");
      chk_rd(12'h808, 32'h1003, "R3 mstat2 enabled");
      chk_rd(12'h80C, 32'h0, "R8 other domain untouched");
      chk_rd(12'hA00, 32'h103, "R2 mctl0 readback");
      wr(12'hA0C, 32'h100);

      // R10 leaving enabled without force waits for ack
      wr(12'hA00, 32'h102);
      wr(12'h120, 32'h1);
      idle(10);
      chk_rd(12'h128, 32'h1, "R10 stalled on ack");
      cmp({31'd0, mod_clk_en[0]}, 32'h1, "R10 clock still on");
      @(posedge clk); #1 mod_idle_ack[0] = 1'b1;
      idle(6);
      chk_rd(12'h800, 32'h2, "R10 disabled after ack");
      @(posedge clk); #1 mod_idle_ack[0] = 1'b0;

      // R10 force flag
      wr(12'hA08, 32'h8000_0102);
      wr(12'h120, 32'h1);
      idle(6);
      chk_rd(12'h808, 32'h2, "R10 forced disable");
      chk_rd(12'hA08, 32'h8000_0102, "R2 force readback");

      // R9 power down domain 1
      wr(12'h304, 32'h0);
      wr(12'h120, 32'h2);
      idle(6);
      chk_rd(12'h204, 32'h0, "R9 domain off");

      // R4 R5 power up with handshake
      wr(12'hA04, 32'h103);
      wr(12'h304, 32'h1);
      wr(12'h120, 32'h2);
      idle(10);
      cmp({30'd0, pwr_req}, 32'h2, "R4 pwr_req pin");
      chk_rd(12'h070, 32'h2, "R4 preq word");
      chk_rd(12'h128, 32'h2, "R4 busy held");
      chk_rd(12'h804, 32'h0, "R5 modules wait");
      wr(12'h304, 32'h101);
      idle(8);
      chk_rd(12'h204, 32'h1, "R5 domain on");
      chk_rd(12'h804, 32'h1003, "R5 module moved");
      chk_rd(12'h070, 32'h0, "R5 request cleared");

      // R7 local reset independent of state
      wr(12'hA0C, 32'h000);
      cmp({31'd0, mod_lrst_n[3]}, 32'h0, "R7 lrst asserted");
      chk_rd(12'h80C, 32'h0, "R7 state unchanged");
      wr(12'hA14, 32'h003);
      wr(12'hA0C, 32'h103);
      wr(12'h120, 32'h2);
      idle(6);
      chk_rd(12'h814, 32'h1003, "R7 enabled under local reset");
      cmp({31'd0, mod_lrst_n[5]}, 32'h0, "R7 lrst still held");
      cmp({31'd0, mod_lrst_n[3]}, 32'h1, "R7 lrst released");
      chk_rd(12'h804, 32'h1003, "R8 equal target untouched");

      // R12 unmapped, misaligned, read-only
      chk_rd(12'h004, 32'h0, "R12 unmapped");
      chk_rd(12'h124, 32'h0, "R12 gap");
      chk_rd(12'h818, 32'h0, "R12 module index range");
      chk_rd(12'h208, 32'h0, "R12 domain index range");
      chk_rd(12'h802, 32'h0, "R12 misaligned");
      wr(12'h128, 32'hFF);
      chk_rd(12'h128, 32'h0, "R12 busy read only");
      wr(12'h800, 32'h0);
      chk_rd(12'h800, 32'h2, "R12 status read only");

      // R13 two domains in one go
      @(posedge clk); #1 mod_idle_ack = '1;
      wr(12'hA10, 32'h101);
      wr(12'hA04, 32'h102);
      wr(12'h120, 32'h3);
      chk_rd(12'h128, 32'h3, "R13 both busy");
      idle(8);
      chk_rd(12'h810, 32'h1, "R13 domain0 module");
      chk_rd(12'h804, 32'h2, "R13 domain1 module");
      chk_rd(12'h128, 32'h0, "R13 both done");

      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule